// File: doc/BRIEF.md
# Fast Privileged-Return State Unit

This block works out the architectural state for a fast return from kernel level to user level on a core with x86-style segmentation and a 64-bit long mode. A pulse on `start` samples the inputs. These are the privilege level, the mode indicators, the vendor-strictness flavour, the operand size, the feature-enable bit, the selector model register, the return-address and saved-flags registers, the live flags and the live stack-segment attributes. On the next cycle, `done` pulses and one of two results is presented.

The first result is a fault code, either invalid-opcode or general-protection. The second is the complete new state: code and stack selectors with their hidden attributes, instruction pointer and flags.

The surrounding core commits the state or delivers the fault. This block does not load descriptors from memory and does not deliver faults.

Top module: `fkr_unit`

## Requirements
- R1: When `feat_en` is 0, the result is fault code 1 (invalid opcode). This check takes priority over every other check.
- R2: When `strict_vendor` is 1 and `long_mode` is 0, the result is fault code 1. Only R1 takes priority over this check.
- R3: When the earlier checks pass and `prot_en` is 0, the result is fault code 2 (general protection).
- R4: When the earlier checks pass and `cpl` is not 0, the result is fault code 2.
- R5: The base selector is `tgt_sel[63:48]` with its low two bits cleared. The stack selector is base+8. The code selector is base+16 when `op64` is 1 and base otherwise. All sums wrap at 16 bits. Both output selectors have their low two bits forced to 3.
- R6: When the earlier checks pass and the code selector or the stack selector is zero after wrap, the result is fault code 2.
- R7: The new instruction pointer and the code-segment attributes depend on the mode:
  - With `long_mode`=1 and `op64`=1, `rip_o` is the full `rcx_in` and `cs_attr_o` is 16'hA0FB (long-code bit 13 set).
  - With `long_mode`=1 and `op64`=0, `rip_o` is `rcx_in[31:0]` zero-extended and `cs_attr_o` is 16'hC0FB.
  - With `long_mode`=0, `rip_o` is `rcx_in` and `cs_attr_o` is 16'hC0FB.
- R8: In long mode, `flags_o` = (`r11_in` & 64'h3C_7FD5) | 2. This keeps only the arithmetic, trap, interrupt, direction, I/O-privilege, nested, alignment, virtual-interrupt and identification bits, and clears bits 16 and 17.
- R9: Outside long mode, `flags_o` = `flags_in` | 64'h200, which sets the interrupt-enable bit.
- R10: `ss_attr_o` = `ss_attr_in` | 16'h0060, which forces privilege level 3 in bits 6:5 and leaves every other bit as it was. On success, `cs_base_o` is 0 and `cs_limit_o` is 32'hFFFF_FFFF.
- R11: `done_o` is 1 exactly in the cycle after each `start` cycle. When the result is a success, `fault_o` is 0.
- R12: On a fault, none of the state outputs change. The fault code stays on `fault_o` until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample the inputs and evaluate |
| cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protection enabled |
| long_mode | input | 1 | Long mode active |
| strict_vendor | input | 1 | Flavour that requires long mode |
| op64 | input | 1 | Effective operand size is 64 bits |
| feat_en | input | 1 | Fast-call feature enable |
| tgt_sel | input | 64 | Selector model register |
| rcx_in | input | 64 | Return address register |
| r11_in | input | 64 | Saved flags register |
| flags_in | input | 64 | Current flags |
| ss_attr_in | input | 16 | Current stack-segment attributes |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| cs_sel_o | output | 16 | New code selector |
| cs_attr_o | output | 16 | New code attributes |
| cs_base_o | output | 64 | New code base |
| cs_limit_o | output | 32 | New code limit |
| ss_sel_o | output | 16 | New stack selector |
| ss_attr_o | output | 16 | New stack attributes |
| rip_o | output | 64 | New instruction pointer |
| flags_o | output | 64 | New flags |

## Verification
The stimulus sweeps every combination of privilege level, protection enable, long mode, vendor flavour, operand size and feature enable. Each combination is tried against five selector-field values:
- a zero field, which separates the code-zero fault from a success;
- a field whose only set bits are the RPL bits, which shows that those bits are cleared;
- an ordinary selector;
- a field whose stack sum wraps to zero;
- a field whose 64-bit code sum wraps to zero.

Together these show the fault priority order and the +16 adjustment. The return-address and saved-flags values have bits set above bit 31 and in the excluded flag positions. This separates full-width from zero-extended addresses, and masked flag restore from pass-through.

// File: rtl/fkr_pkg.sv
package fkr_pkg;
   localparam logic [1:0] FC_NONE = 2'd0;
   localparam logic [1:0] FC_UD   = 2'd1;
   localparam logic [1:0] FC_GP   = 2'd2;

   // attribute word bit positions
   localparam int AT_TYPE_LSB = 0;
   localparam int AT_S        = 4;
   localparam int AT_DPL_LSB  = 5;
   localparam int AT_P        = 7;
   localparam int AT_L        = 13;
   localparam int AT_D        = 14;
   localparam int AT_G        = 15;
   localparam logic [3:0] TYPE_CODE_ER_ACC = 4'hB;

   // flag bit positions
   localparam int FL_CF = 0;  localparam int FL_ONE = 1; localparam int FL_PF = 2;
   localparam int FL_AF = 4;  localparam int FL_ZF  = 6; localparam int FL_SF = 7;
   localparam int FL_TF = 8;  localparam int FL_IF  = 9; localparam int FL_DF = 10;
   localparam int FL_OF = 11; localparam int FL_IOPL0 = 12; localparam int FL_IOPL1 = 13;
   localparam int FL_NT = 14; localparam int FL_AC  = 18; localparam int FL_VIF = 19;
   localparam int FL_VIP = 20; localparam int FL_ID = 21;

   localparam int KEEP_N = 16;
   typedef int keep_list_t [KEEP_N];
   localparam keep_list_t KEEP_BITS = '{FL_CF, FL_PF, FL_AF, FL_ZF, FL_SF, FL_TF, FL_IF,
      FL_DF, FL_OF, FL_IOPL0, FL_IOPL1, FL_NT, FL_AC, FL_VIF, FL_VIP, FL_ID};

   function automatic logic [31:0] code_attr(input logic wide);
      logic [31:0] a;
      a = '0;
      a[AT_TYPE_LSB +: 4] = TYPE_CODE_ER_ACC;
      a[AT_S] = 1'b1;
      a[AT_DPL_LSB +: 2] = 2'd3;
      a[AT_P] = 1'b1;
      a[AT_G] = 1'b1;
      if (wide) a[AT_L] = 1'b1;
      else      a[AT_D] = 1'b1;
      return a;
   endfunction
endpackage

// File: rtl/fkr_selgen.sv
module fkr_selgen #(
   parameter int SEL_W = 16
) (
   input  logic [SEL_W-1:0] sel_field,
   input  logic             op64,
   output logic [SEL_W-1:0] cs_raw,
   output logic [SEL_W-1:0] ss_raw,
   output logic             sel_zero
);
   localparam logic [SEL_W-1:0] RPL_CLR = ~SEL_W'(3);
   localparam logic [SEL_W-1:0] SS_OFS  = SEL_W'(8);
   localparam logic [SEL_W-1:0] CS_OFS  = SEL_W'(16);

   if (SEL_W < 8) begin : g_bad_w
      $error("fkr_selgen: SEL_W too small");
   end

   logic [SEL_W-1:0] base;
   always_comb begin
      base     = sel_field & RPL_CLR;
      ss_raw   = base + SS_OFS;
      cs_raw   = op64 ? base + CS_OFS : base;
      sel_zero = (cs_raw == '0) || (ss_raw == '0);
   end
endmodule

// File: rtl/fkr_gate.sv
module fkr_gate (
   input  logic       feat_en,
   input  logic       strict_vendor,
   input  logic       long_mode,
   input  logic       prot_en,
   input  logic [1:0] cpl,
   input  logic       sel_zero,
   output logic [1:0] fault
);
   import fkr_pkg::*;
   always_comb begin
      if (!feat_en)                       fault = FC_UD;
      else if (strict_vendor && !long_mode) fault = FC_UD;
      else if (!prot_en)                  fault = FC_GP;
      else if (cpl != 2'd0)               fault = FC_GP;
      else if (sel_zero)                  fault = FC_GP;
      else                                fault = FC_NONE;
   end
endmodule

// File: rtl/fkr_flagmix.sv
module fkr_flagmix #(
   parameter int ADDR_W = 64,
   parameter int ATTR_W = 16
) (
   input  logic              long_mode,
   input  logic              op64,
   input  logic [ADDR_W-1:0] rcx_in,
   input  logic [ADDR_W-1:0] r11_in,
   input  logic [ADDR_W-1:0] flags_in,
   input  logic [ATTR_W-1:0] ss_attr_in,
   output logic [ADDR_W-1:0] rip,
   output logic [ADDR_W-1:0] flags,
   output logic [ATTR_W-1:0] cs_attr,
   output logic [ATTR_W-1:0] ss_attr
);
   import fkr_pkg::*;

   if (ADDR_W < 32) begin : g_bad_a
      $error("fkr_flagmix: ADDR_W below 32");
   end
   if (ATTR_W < 16) begin : g_bad_t
      $error("fkr_flagmix: ATTR_W below 16");
   end

   // restore mask built bit by bit
   logic [ADDR_W-1:0] keep_mask;
   for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int k = 0; k < KEEP_N; k++)
            if (KEEP_BITS[k] == i) hit = 1'b1;
      end
      assign keep_mask[i] = hit;
   end

   localparam logic [ADDR_W-1:0] ONE_BIT = ADDR_W'(1) << FL_ONE;
   localparam logic [ADDR_W-1:0] IF_BIT  = ADDR_W'(1) << FL_IF;
   localparam logic [ATTR_W-1:0] DPL3    = ATTR_W'(3) << AT_DPL_LSB;
   localparam logic [ATTR_W-1:0] CS_WIDE = ATTR_W'(code_attr(1'b1));
   localparam logic [ATTR_W-1:0] CS_NARR = ATTR_W'(code_attr(1'b0));

   always_comb begin
      if (long_mode) begin
         rip     = op64 ? rcx_in : {{(ADDR_W-32){1'b0}}, rcx_in[31:0]};
         cs_attr = op64 ? CS_WIDE : CS_NARR;
         flags   = (r11_in & keep_mask) | ONE_BIT;
      end else begin
         rip     = rcx_in;
         cs_attr = CS_NARR;
         flags   = flags_in | IF_BIT;
      end
      ss_attr = ss_attr_in | DPL3;
   end
endmodule

// File: rtl/fkr_unit.sv
module fkr_unit #(
   parameter int ADDR_W  = 64,
   parameter int SEL_W   = 16,
   parameter int SEL_LSB = 48,
   parameter int ATTR_W  = 16,
   parameter int LIM_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        cpl,
   input  logic              prot_en,
   input  logic              long_mode,
   input  logic              strict_vendor,
   input  logic              op64,
   input  logic              feat_en,
   input  logic [ADDR_W-1:0] tgt_sel,
   input  logic [ADDR_W-1:0] rcx_in,
   input  logic [ADDR_W-1:0] r11_in,
   input  logic [ADDR_W-1:0] flags_in,
   input  logic [ATTR_W-1:0] ss_attr_in,
   output logic              done_o,
   output logic [1:0]        fault_o,
   output logic [SEL_W-1:0]  cs_sel_o,
   output logic [ATTR_W-1:0] cs_attr_o,
   output logic [ADDR_W-1:0] cs_base_o,
   output logic [LIM_W-1:0]  cs_limit_o,
   output logic [SEL_W-1:0]  ss_sel_o,
   output logic [ATTR_W-1:0] ss_attr_o,
   output logic [ADDR_W-1:0] rip_o,
   output logic [ADDR_W-1:0] flags_o
);
   import fkr_pkg::*;

   localparam logic [SEL_W-1:0] RPL3 = SEL_W'(3);

   if (SEL_LSB + SEL_W > ADDR_W) begin : g_bad_field
      $error("fkr_unit: selector field outside register");
   end

   logic [SEL_W-1:0]  cs_raw, ss_raw;
   logic              sel_zero;
   logic [1:0]        fault_n;
   logic [ADDR_W-1:0] rip_n, flags_n;
   logic [ATTR_W-1:0] cs_attr_n, ss_attr_n;

   fkr_selgen #(.SEL_W(SEL_W)) u_sel (
      .sel_field(tgt_sel[SEL_LSB +: SEL_W]), .op64(op64),
      .cs_raw(cs_raw), .ss_raw(ss_raw), .sel_zero(sel_zero));

   fkr_gate u_gate (
      .feat_en(feat_en), .strict_vendor(strict_vendor), .long_mode(long_mode),
      .prot_en(prot_en), .cpl(cpl), .sel_zero(sel_zero), .fault(fault_n));

   fkr_flagmix #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_mix (
      .long_mode(long_mode), .op64(op64), .rcx_in(rcx_in), .r11_in(r11_in),
      .flags_in(flags_in), .ss_attr_in(ss_attr_in), .rip(rip_n), .flags(flags_n),
      .cs_attr(cs_attr_n), .ss_attr(ss_attr_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o     <= 1'b0;
         fault_o    <= FC_NONE;
         cs_sel_o   <= '0;
         cs_attr_o  <= '0;
         cs_base_o  <= '0;
         cs_limit_o <= '0;
         ss_sel_o   <= '0;
         ss_attr_o  <= '0;
         rip_o      <= '0;
         flags_o    <= '0;
      end else begin
         done_o <= start;
         if (start) begin
            fault_o <= fault_n;
            if (fault_n == FC_NONE) begin
               cs_sel_o   <= cs_raw | RPL3;
               ss_sel_o   <= ss_raw | RPL3;
               cs_attr_o  <= cs_attr_n;
               ss_attr_o  <= ss_attr_n;
               cs_base_o  <= '0;
               cs_limit_o <= '1;
               rip_o      <= rip_n;
               flags_o    <= flags_n;
            end
         end
      end
   end

   // R1
   a_r1_feat_ud: assert property (@(posedge clk) disable iff (!rst_n)
      start && !feat_en |=> fault_o == FC_UD);
   // R2
   a_r2_vendor_ud: assert property (@(posedge clk) disable iff (!rst_n)
      start && feat_en && strict_vendor && !long_mode |=> fault_o == FC_UD);
   // R4
   a_r4_cpl_gp: assert property (@(posedge clk) disable iff (!rst_n)
      start && feat_en && !(strict_vendor && !long_mode) && prot_en && cpl != 2'd0
      |=> fault_o == FC_GP);
   // R5
   a_r5_rpl3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o == FC_NONE |-> cs_sel_o[1:0] == 2'd3 && ss_sel_o[1:0] == 2'd3);
   // R8
   a_r8_bit1: assert property (@(posedge clk) disable iff (!rst_n)
      start && long_mode && fault_n == FC_NONE |=> flags_o[FL_ONE] && !flags_o[16] && !flags_o[17]);
   // R11
   a_r11_done: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done_o);
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done_o && $stable(fault_o));
   // R12
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      start && fault_n != FC_NONE |=> $stable(rip_o) && $stable(cs_sel_o) && $stable(flags_o));
endmodule

// File: tb/fkr_unit_tb.sv
`timescale 1ns/1ps
module fkr_unit_tb;
   logic clk = 0, rst_n = 0, start = 0;
   logic [1:0] cpl = 0;
   logic prot_en = 0, long_mode = 0, strict_vendor = 0, op64 = 0, feat_en = 0;
   logic [63:0] tgt_sel = 0, rcx_in = 0, r11_in = 0, flags_in = 0;
   logic [15:0] ss_attr_in = 0;
   logic done_o; logic [1:0] fault_o;
   logic [15:0] cs_sel_o, cs_attr_o, ss_sel_o, ss_attr_o;
   logic [63:0] cs_base_o, rip_o, flags_o; logic [31:0] cs_limit_o;

   int total = 0, bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   fkr_unit u_dut (.clk, .rst_n, .start, .cpl, .prot_en, .long_mode, .strict_vendor,
      .op64, .feat_en, .tgt_sel, .rcx_in, .r11_in, .flags_in, .ss_attr_in, .done_o,
      .fault_o, .cs_sel_o, .cs_attr_o, .cs_base_o, .cs_limit_o, .ss_sel_o, .ss_attr_o,
      .rip_o, .flags_o);

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   logic [15:0] p_cs, p_ss, p_ca, p_sa; logic [63:0] p_rip, p_fl;

   task automatic run_one(input int idx, input logic [15:0] fld);
      logic [15:0] base, cs, ss; logic [1:0] ef;
      logic [63:0] erip, efl; logic [15:0] eca;
      @(negedge clk);
      tgt_sel  = {fld, 48'h1357_9BDF_2468};
      rcx_in   = 64'hFEDC_BA98_7654_3210 ^ 64'(idx);
      r11_in   = 64'hFFFF_FFFF_FFFF_FFFF ^ (64'(idx) << 3);
      flags_in = 64'h0000_0000_0003_0802 ^ 64'(idx & 8'hC0);
      ss_attr_in = 16'h0C93 ^ 16'(idx << 8);
      start = 1;
      p_cs = cs_sel_o; p_ss = ss_sel_o; p_ca = cs_attr_o; p_sa = ss_attr_o;
      p_rip = rip_o; p_fl = flags_o;
      @(negedge clk);
      start = 0;
      base = fld & 16'hFFFC; ss = base + 16'd8; cs = op64 ? base + 16'd16 : base;
      if (!feat_en) ef = 1;
      else if (strict_vendor && !long_mode) ef = 1;
      else if (!prot_en) ef = 2;
      else if (cpl != 0) ef = 2;
      else if (cs == 0 || ss == 0) ef = 2;
      else ef = 0;
      chk(done_o === 1'b1, "R11 done", 64'(done_o), 64'd1);
      chk(fault_o === ef, (ef == 1) ? "R1/R2 ud" : (ef == 2) ? "R3/R4/R6 gp" : "R11 nofault",
          64'(fault_o), 64'(ef));
      if (ef == 0) begin
         erip = long_mode ? (op64 ? rcx_in : {32'h0, rcx_in[31:0]}) : rcx_in;
         eca  = (long_mode && op64) ? 16'hA0FB : 16'hC0FB;
         efl  = long_mode ? ((r11_in & 64'h3C_7FD5) | 64'h2) : (flags_in | 64'h200);
         chk(cs_sel_o === (cs | 16'd3), "R5 cs_sel", 64'(cs_sel_o), 64'(cs | 16'd3));
         chk(ss_sel_o === (ss | 16'd3), "R5 ss_sel", 64'(ss_sel_o), 64'(ss | 16'd3));
         chk(rip_o === erip, "R7 rip", rip_o, erip);
         chk(cs_attr_o === eca, "R7 cs_attr", 64'(cs_attr_o), 64'(eca));
         chk(flags_o === efl, long_mode ? "R8 flags" : "R9 flags", flags_o, efl);
         chk(ss_attr_o === (ss_attr_in | 16'h60), "R10 ss_attr", 64'(ss_attr_o), 64'(ss_attr_in | 16'h60));
         chk(cs_base_o === 0 && cs_limit_o === 32'hFFFF_FFFF, "R10 base/limit",
             {cs_base_o[31:0], cs_limit_o}, 64'hFFFF_FFFF);
      end else begin
         chk(rip_o === p_rip && flags_o === p_fl && cs_sel_o === p_cs && ss_sel_o === p_ss
             && cs_attr_o === p_ca && ss_attr_o === p_sa, "R12 held", rip_o, p_rip);
      end
      @(negedge clk);
      chk(done_o === 1'b0 && fault_o === ef, "R12 code kept", {done_o, fault_o}, {1'b0, ef});
   endtask

   initial begin
      logic [15:0] flds [5];
      int idx;
      flds = '{16'h0000, 16'h0003, 16'h0023, 16'hFFF8, 16'hFFF2};
      idx = 0;
      repeat (3) @(negedge clk);
      chk(done_o === 0 && fault_o === 0 && rip_o === 0, "R11 reset", rip_o, 64'd0);
      rst_n = 1;
      for (int c = 0; c < 128; c++) begin
         {cpl, prot_en, long_mode, strict_vendor, op64, feat_en} = 7'(c);
         for (int f = 0; f < 5; f++) begin
            run_one(idx, flds[f]);
            idx++;
         end
      end
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule